// File: doc/BRIEF.md
# Continuous ADC Scan Sequencer

This block controls a 12-bit successive-approximation converter in a continuous scanning mode. Each scan starts with a sampling window followed by a holding window. During these windows every channel that has its own sample-and-hold circuit captures its input at the same time. Next comes a self-diagnosis conversion of a reference level, and then one conversion for each enabled channel in the channel bitmap. Results are kept in a diagnosis register and in one result register per channel. The next scan's sampling window opens in the same cycle that the scan-end interrupt pulse appears.

Software holds `run_i` high to keep scanning. Scans repeat until `run_i` is cleared, and the hardware never clears it. The analog converter is outside the block. The block asks for a conversion with a one-cycle `conv_start_o` pulse. The converter answers with a one-cycle `conv_done_i` carrying `conv_data_i`. Only one conversion is outstanding at any time, and the sequencer accepts the answer in any cycle, so there is no back-pressure on the result path. The temperature-sensor and internal-reference select inputs are not allowed in this mode. They only raise a configuration-error flag.

Top module: `adc_scan_seq`

## Requirements
- R1: From idle, a scan begins only when `run_i` is 1 and a start event occurs. A start event is `sw_trig_i` or `sync_trig_i` high at a clock edge, or a rising edge of `async_trig_i`. The asynchronous input passes through a two-flop synchronizer, so it takes effect within four cycles.
- R2: A scan opens with `sh_sample_o` high for max(`samp_cycles_i`,1) cycles. Then `sh_hold_o` is high for max(`hold_cycles_i`,1) cycles. The two are never high together.
- R3: After the hold window, the first conversion of every scan is a diagnosis conversion, marked by `diag_active_o`. Its result is written only to `diag_result_o`.
- R4: `diag_sel_o` encodes the reference level as 2'b00 zero, 2'b01 half scale and 2'b10 full scale. It is 2'b00 after reset and advances 00→01→10→00 after each completed diagnosis conversion. An aborted diagnosis does not advance it.
- R5: After the diagnosis, only the channels whose bit is set in `ch_en_i` are converted, in ascending index order. `mux_sel_o` carries the channel index.
- R6: Each channel result goes into slice `ch_result_o[c*12 +: 12]` when its conversion completes. Slices of disabled channels keep their value.
- R7: When the last conversion of a scan completes, `scan_irq_o` is high for exactly one cycle if `irq_en_i` was 1, and otherwise stays low. That cycle is also the first cycle of the next `sh_sample_o` window.
- R8: Scans repeat while `run_i` stays 1. With an all-zero bitmap, the scan ends right after the diagnosis conversion.
- R9: Clearing `run_i` during sampling or holding returns the block to idle at the next edge. Clearing it during a conversion waits for `conv_done_i`, then goes idle without writing a result or raising the interrupt.
- R10: `temp_sel_i` or `iref_sel_i` high sets `cfg_err_o` one cycle later. Neither input has any effect on the scan.
- R11: After reset, all strobes, the interrupt, the diagnosis register and every channel result register are 0.
- R12: `conv_start_o` is a one-cycle pulse. No new request is issued before the pending conversion's `conv_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Software run bit; scanning continues while high |
| sw_trig_i | input | 1 | Software start event |
| sync_trig_i | input | 1 | Synchronous start event from on-chip timer logic |
| async_trig_i | input | 1 | Asynchronous external start input |
| ch_en_i | input | NCH | Channel enable bitmap |
| irq_en_i | input | 1 | Scan-end interrupt enable |
| temp_sel_i | input | 1 | Temperature-sensor select (forbidden in this mode) |
| iref_sel_i | input | 1 | Internal-reference select (forbidden in this mode) |
| samp_cycles_i | input | CW | Sampling window length in cycles |
| hold_cycles_i | input | CW | Holding window length in cycles |
| conv_done_i | input | 1 | Converter result valid (one cycle) |
| conv_data_i | input | DW | Converter result |
| conv_start_o | output | 1 | Conversion request pulse |
| sh_sample_o | output | 1 | Sample strobe for dedicated sample-and-hold channels |
| sh_hold_o | output | 1 | Hold strobe for dedicated sample-and-hold channels |
| mux_sel_o | output | $clog2(NCH) | Analog multiplexer channel index |
| diag_active_o | output | 1 | Current conversion is the diagnosis conversion |
| diag_sel_o | output | 2 | Diagnosis reference level code |
| diag_result_o | output | DW | Diagnosis result register |
| ch_result_o | output | NCH*DW | Per-channel result registers, channel c at [c*DW +: DW] |
| scan_irq_o | output | 1 | Scan-complete interrupt pulse |
| cfg_err_o | output | 1 | Forbidden select seen |

## Verification
The bench drives a zero-length sampling window and checks it is stretched to one cycle. A design that trusted the count would stall or skip the strobe. It also runs an empty bitmap, which must close the scan straight after the diagnosis. A sequencer that hunted for a first channel would hang there or convert channel 0. Aborts are tested both inside a channel conversion and inside the diagnosis. A wrong design would store the late result, fire the interrupt, or advance the reference level, and the next scan's diagnosis code exposes that last fault. Sparse and wrap-around bitmaps, a disabled interrupt, and starts from the synchronous and asynchronous inputs complete the set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_HOLD,
    ST_DREQ,
    ST_DWAIT,
    ST_CREQ,
    ST_CWAIT
  } seq_state_e;

  localparam logic [1:0] REF_ZERO = 2'b00;
  localparam logic [1:0] REF_HALF = 2'b01;
  localparam logic [1:0] REF_FULL = 2'b10;

  function automatic logic [1:0] ref_advance(input logic [1:0] cur);
    case (cur)
      REF_ZERO: ref_advance = REF_HALF;
      REF_HALF: ref_advance = REF_FULL;
      default:  ref_advance = REF_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic evt_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], async_i};
  end

  assign evt_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/adc_ch_pick.sv
module adc_ch_pick #(
  parameter int NCH = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [IW:0]    from_i,
  output logic           found_o,
  output logic [IW-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(from_i))) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q <= CW'(1));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 12,
  parameter int CW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              sw_trig_i,
  input  logic              sync_trig_i,
  input  logic              async_trig_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic              irq_en_i,
  input  logic              temp_sel_i,
  input  logic              iref_sel_i,
  input  logic [CW-1:0]     samp_cycles_i,
  input  logic [CW-1:0]     hold_cycles_i,
  input  logic              conv_done_i,
  input  logic [DW-1:0]     conv_data_i,
  output logic              conv_start_o,
  output logic              sh_sample_o,
  output logic              sh_hold_o,
  output logic [IW-1:0]     mux_sel_o,
  output logic              diag_active_o,
  output logic [1:0]        diag_sel_o,
  output logic [DW-1:0]     diag_result_o,
  output logic [NCH*DW-1:0] ch_result_o,
  output logic              scan_irq_o,
  output logic              cfg_err_o
);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] chan_q, chan_d;
  logic [1:0]    ref_q;
  logic [DW-1:0] diag_q;
  logic          irq_q, cfg_q;
  logic          async_evt, start_evt;
  logic          tmr_load, tmr_last;
  logic [CW-1:0] tmr_len;
  logic          scan_end, diag_wr, ch_wr;
  logic          first_found, next_found;
  logic [IW-1:0] first_idx, next_idx;
  logic [IW:0]   next_from;

  adc_trig_sync u_async (
    .clk   (clk),
    .rst_n (rst_n),
    .async_i (async_trig_i),
    .evt_o (async_evt)
  );

  assign start_evt = sw_trig_i | sync_trig_i | async_evt;

  adc_phase_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  assign next_from = {1'b0, chan_q} + 1'b1;

  adc_ch_pick #(.NCH(NCH)) u_first (
    .mask_i  (ch_en_i),
    .from_i  ('0),
    .found_o (first_found),
    .idx_o   (first_idx)
  );

  adc_ch_pick #(.NCH(NCH)) u_next (
    .mask_i  (ch_en_i),
    .from_i  (next_from),
    .found_o (next_found),
    .idx_o   (next_idx)
  );

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    tmr_load = 1'b0;
    tmr_len  = samp_cycles_i;
    scan_end = 1'b0;
    diag_wr  = 1'b0;
    ch_wr    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (run_i && start_evt) begin
          state_d  = ST_SAMPLE;
          tmr_load = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (!run_i) state_d = ST_IDLE;
        else if (tmr_last) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_len  = hold_cycles_i;
        end
      end
      ST_HOLD: begin
        if (!run_i)        state_d = ST_IDLE;
        else if (tmr_last) state_d = ST_DREQ;
      end
      ST_DREQ: state_d = ST_DWAIT;
      ST_DWAIT: begin
        if (conv_done_i) begin
          if (!run_i) state_d = ST_IDLE;
          else begin
            diag_wr = 1'b1;
            if (first_found) begin
              state_d = ST_CREQ;
              chan_d  = first_idx;
            end else scan_end = 1'b1;
          end
        end
      end
      ST_CREQ: state_d = ST_CWAIT;
      ST_CWAIT: begin
        if (conv_done_i) begin
          if (!run_i) state_d = ST_IDLE;
          else begin
            ch_wr = 1'b1;
            if (next_found) begin
              state_d = ST_CREQ;
              chan_d  = next_idx;
            end else scan_end = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (scan_end) begin
      state_d  = ST_SAMPLE;
      tmr_load = 1'b1;
      tmr_len  = samp_cycles_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      ref_q   <= REF_ZERO;
      diag_q  <= '0;
      irq_q   <= 1'b0;
      cfg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      irq_q   <= scan_end & irq_en_i;
      cfg_q   <= temp_sel_i | iref_sel_i;
      if (diag_wr) begin
        diag_q <= conv_data_i;
        ref_q  <= ref_advance(ref_q);
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_res
    logic [DW-1:0] res_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            res_q <= '0;
      else if (ch_wr && chan_q == IW'(c))    res_q <= conv_data_i;
    end
    assign ch_result_o[c*DW +: DW] = res_q;
  end

  assign sh_sample_o   = (state_q == ST_SAMPLE);
  assign sh_hold_o     = (state_q == ST_HOLD);
  assign conv_start_o  = (state_q == ST_DREQ) || (state_q == ST_CREQ);
  assign diag_active_o = (state_q == ST_DREQ) || (state_q == ST_DWAIT);
  assign mux_sel_o     = chan_q;
  assign diag_sel_o    = ref_q;
  assign diag_result_o = diag_q;
  assign scan_irq_o    = irq_q;
  assign cfg_err_o     = cfg_q;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_en_i,
  input logic           irq_en_i,
  input logic           conv_start_o,
  input logic           sh_sample_o,
  input logic           sh_hold_o,
  input logic [IW-1:0]  mux_sel_o,
  input logic           diag_active_o,
  input logic [1:0]     diag_sel_o,
  input logic           scan_irq_o
);

  assert_sh_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_sample_o && sh_hold_o));

  assert_hold_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_hold_o) |-> $past(sh_sample_o));

  assert_ref_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    diag_sel_o != 2'b11);

  assert_ref_stable_in_diag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_active_o && !conv_start_o) |-> $stable(diag_sel_o));

  assert_chan_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start_o && !diag_active_o) |-> ch_en_i[mux_sel_o]);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq_o |=> !scan_irq_o);

  assert_irq_with_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq_o |-> sh_sample_o);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq_o |-> $past(irq_en_i));

  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ch_en_i       (ch_en_i),
  .irq_en_i      (irq_en_i),
  .conv_start_o  (conv_start_o),
  .sh_sample_o   (sh_sample_o),
  .sh_hold_o     (sh_hold_o),
  .mux_sel_o     (mux_sel_o),
  .diag_active_o (diag_active_o),
  .diag_sel_o    (diag_sel_o),
  .scan_irq_o    (scan_irq_o)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int CW  = 8;

  // {tag[28:25], hold[24:17], samp[16:9], irq_en[8], ch_en[7:0]}
  localparam logic [28:0] VEC [6] = '{
    {4'd1, 8'd2, 8'd3, 1'b1, 8'b0000_0101},
    {4'd2, 8'd1, 8'd1, 1'b0, 8'b1000_0001},
    {4'd3, 8'd4, 8'd0, 1'b1, 8'hFF},
    {4'd4, 8'd1, 8'd2, 1'b1, 8'h00},
    {4'd5, 8'd0, 8'd5, 1'b1, 8'b0110_0000},
    {4'd6, 8'd2, 8'd2, 1'b0, 8'h10}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, run_i, sw_trig_i, sync_trig_i, async_trig_i;
  logic [NCH-1:0] ch_en_i;
  logic irq_en_i, temp_sel_i, iref_sel_i;
  logic [CW-1:0] samp_cycles_i, hold_cycles_i;
  logic conv_done_i;
  logic [DW-1:0] conv_data_i;
  logic conv_start_o, sh_sample_o, sh_hold_o, diag_active_o, scan_irq_o, cfg_err_o;
  logic [2:0] mux_sel_o;
  logic [1:0] diag_sel_o;
  logic [DW-1:0] diag_result_o;
  logic [NCH*DW-1:0] ch_result_o;

  adc_scan_seq #(.NCH(NCH), .DW(DW), .CW(CW)) dut (.*);

  int checks = 0;
  int errors = 0;
  logic [3:0]    tag_r = 4'd0;
  logic [2:0]    log_ch [256];
  logic [7:0]    log_n = 8'd0;
  int            irq_cnt = 0;
  logic [DW-1:0] exp_res [NCH];
  logic [1:0]    exp_ref = 2'b00;

  // converter model: 3-cycle latency, one request at a time
  logic          pend = 1'b0;
  logic [1:0]    lat = 2'd0;
  logic [DW-1:0] pdata = '0;
  always @(posedge clk) begin
    conv_done_i <= 1'b0;
    if (pend) begin
      if (lat == 2'd0) begin
        conv_done_i <= 1'b1;
        conv_data_i <= pdata;
        pend <= 1'b0;
      end else lat <= lat - 2'd1;
    end
    if (conv_start_o) begin
      pend <= 1'b1;
      lat  <= 2'd2;
      if (diag_active_o) pdata <= 12'hD00 | {10'b0, diag_sel_o};
      else begin
        pdata <= {tag_r, 5'b0, mux_sel_o};
        log_ch[log_n] <= mux_sel_o;
        log_n <= log_n + 8'd1;
      end
    end
    if (scan_irq_o) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_scan(input logic [7:0] ch, input bit irq, input logic [7:0] s,
                          input logic [7:0] h, input logic [3:0] tag);
    int n, exp_n, to, base_irq, k;
    logic [7:0] base_log;
    bit irq_seen;
    logic [DW-1:0] got;
    ch_en_i = ch; irq_en_i = irq; samp_cycles_i = s; hold_cycles_i = h; tag_r = tag;
    base_log = log_n; base_irq = irq_cnt;
    run_i = 1'b1; sw_trig_i = 1'b1;
    @(negedge clk); sw_trig_i = 1'b0;
    n = 0;
    while (sh_sample_o && n < 1000) begin n++; @(negedge clk); end
    exp_n = (s == 0) ? 1 : int'(s);
    chk(n == exp_n, "R2", "sample window", n, exp_n);
    n = 0;
    while (sh_hold_o && n < 1000) begin n++; @(negedge clk); end
    exp_n = (h == 0) ? 1 : int'(h);
    chk(n == exp_n, "R2", "hold window", n, exp_n);
    to = 0;
    while (!sh_sample_o && to < 5000) begin to++; @(negedge clk); end
    chk(to < 5000, "R8", "next scan sampling reached", to, 0);
    irq_seen = scan_irq_o;
    run_i = 1'b0;
    @(negedge clk);
    chk(!sh_sample_o && !sh_hold_o, "R9", "idle after clear in sampling",
        int'(sh_sample_o), 0);
    chk(irq_seen == irq, "R7", "irq with resample", int'(irq_seen), int'(irq));
    chk(irq_cnt - base_irq == int'(irq), "R7", "irq pulse count", irq_cnt - base_irq, int'(irq));
    chk(diag_result_o == (12'hD00 | {10'b0, exp_ref}), "R3", "diag result",
        int'(diag_result_o), int'(12'hD00 | {10'b0, exp_ref}));
    exp_ref = (exp_ref == 2'b10) ? 2'b00 : exp_ref + 2'b01;
    k = 0;
    for (int c = 0; c < NCH; c++) begin
      if (ch[c]) begin
        chk(log_ch[8'(base_log + 8'(k))] == 3'(c), "R5", "conversion order",
            int'(log_ch[8'(base_log + 8'(k))]), c);
        k++;
        exp_res[c] = {tag, 5'b0, 3'(c)};
      end
    end
    chk(int'(8'(log_n - base_log)) == k, "R5", "conversion count",
        int'(8'(log_n - base_log)), k);
    for (int c = 0; c < NCH; c++) begin
      got = ch_result_o[c*DW +: DW];
      chk(got == exp_res[c], "R6", "channel result", int'(got), int'(exp_res[c]));
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base_irq, to;
    logic [DW-1:0] d_before;
    for (int c = 0; c < NCH; c++) exp_res[c] = '0;
    rst_n = 1'b0; run_i = 1'b0; sw_trig_i = 1'b0; sync_trig_i = 1'b0; async_trig_i = 1'b0;
    ch_en_i = '0; irq_en_i = 1'b0; temp_sel_i = 1'b0; iref_sel_i = 1'b0;
    samp_cycles_i = 8'd1; hold_cycles_i = 8'd1; conv_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!sh_sample_o && !sh_hold_o && !conv_start_o && !scan_irq_o, "R11", "strobes idle",
        int'({sh_sample_o, sh_hold_o, conv_start_o, scan_irq_o}), 0);
    chk(diag_result_o == '0 && diag_sel_o == 2'b00, "R11", "diag reset",
        int'(diag_result_o), 0);
    chk(ch_result_o == '0, "R11", "results reset", int'(ch_result_o[31:0]), 0);

    // R1: trigger with run low does nothing
    sw_trig_i = 1'b1; sync_trig_i = 1'b1;
    @(negedge clk); sw_trig_i = 1'b0; sync_trig_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(!sh_sample_o, "R1", "no start without run", int'(sh_sample_o), 0);

    // R1: synchronous trigger
    samp_cycles_i = 8'd20; run_i = 1'b1; sync_trig_i = 1'b1;
    @(negedge clk); sync_trig_i = 1'b0;
    chk(sh_sample_o, "R1", "sync trigger start", int'(sh_sample_o), 1);
    run_i = 1'b0; @(negedge clk);
    chk(!sh_sample_o, "R9", "clear during sampling", int'(sh_sample_o), 0);

    // R1: asynchronous trigger, off-edge
    run_i = 1'b1;
    #3 async_trig_i = 1'b1;
    repeat (2) @(negedge clk);
    async_trig_i = 1'b0;
    to = 0;
    while (!sh_sample_o && to < 8) begin to++; @(negedge clk); end
    chk(sh_sample_o, "R1", "async trigger start", to, 0);
    run_i = 1'b0; repeat (3) @(negedge clk);

    // R10: forbidden selects flagged, walk runs with one held set
    temp_sel_i = 1'b1; repeat (2) @(negedge clk);
    chk(cfg_err_o, "R10", "temp select flagged", int'(cfg_err_o), 1);
    for (int v = 0; v < 6; v++)
      run_scan(VEC[v][7:0], VEC[v][8], VEC[v][16:9], VEC[v][24:17], VEC[v][28:25]);
    temp_sel_i = 1'b0; iref_sel_i = 1'b1; repeat (2) @(negedge clk);
    chk(cfg_err_o, "R10", "iref select flagged", int'(cfg_err_o), 1);
    iref_sel_i = 1'b0; repeat (2) @(negedge clk);
    chk(!cfg_err_o, "R10", "flag clears", int'(cfg_err_o), 0);

    // R9: abort inside a channel conversion
    ch_en_i = 8'h02; irq_en_i = 1'b1; samp_cycles_i = 8'd1; hold_cycles_i = 8'd1; tag_r = 4'd7;
    base_irq = irq_cnt;
    run_i = 1'b1; sw_trig_i = 1'b1; @(negedge clk); sw_trig_i = 1'b0;
    to = 0;
    while (!(conv_start_o && !diag_active_o) && to < 200) begin to++; @(negedge clk); end
    run_i = 1'b0;
    repeat (10) @(negedge clk);
    exp_ref = (exp_ref == 2'b10) ? 2'b00 : exp_ref + 2'b01;
    chk(ch_result_o[1*DW +: DW] == exp_res[1], "R9", "no write on abort",
        int'(ch_result_o[1*DW +: DW]), int'(exp_res[1]));
    chk(irq_cnt == base_irq && !sh_sample_o, "R9", "no irq or rescan on abort",
        irq_cnt - base_irq, 0);

    // R9/R4: abort inside the diagnosis conversion
    d_before = diag_result_o;
    run_i = 1'b1; sw_trig_i = 1'b1; @(negedge clk); sw_trig_i = 1'b0;
    to = 0;
    while (!(conv_start_o && diag_active_o) && to < 200) begin to++; @(negedge clk); end
    run_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(diag_result_o == d_before, "R9", "diag kept on abort",
        int'(diag_result_o), int'(d_before));
    chk(irq_cnt == base_irq, "R9", "no irq after diag abort", irq_cnt - base_irq, 0);

    // R4: aborted diagnosis did not rotate the level
    run_scan(8'h81, 1'b1, 8'd2, 8'd2, 4'd8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule